// File: doc/BRIEF.md
# Privilege-Tagged Trace Merge and Gate

This block collects trace records from a set of on-chip producers (processor core, interconnect, power control, cipher engine and plain functional logic) and merges them into one record stream for a debug trace sink. Every producer port owns a two-bit privilege class. The block stamps that class onto each record at the moment the record is accepted, and no later stage can rewrite it. The class travels with the record to the output, next to the producer index and the 32-bit payload, so a consumer further on can check it again.

A debugger privilege register sits between the merge and the sink. A record goes out only if the debugger level is at least the record's class. A record above that level is taken from its producer and discarded, and a saturating counter for that class is incremented. A discarded record never waits for the output, so a stalled sink does not hold back producers whose records are to be discarded anyway. The debugger level starts at the lowest value after reset and can only be raised, through an authenticated set strobe.

Per-port classes come either from a fixed parameter or from a table that is writable only until a sticky lock is set. A parameter selects which of the two is built. Arbitration among waiting producers is round robin, with one record granted per cycle and valid/ready backpressure on every producer.

Top module: `trace_guard_top`

## Requirements
- R1: After reset, out_valid is 0, dbg_level is 0 and every drop counter is 0.
- R2: Every output record carries the privilege class of the port it entered on, that port's index in out_src, and its payload unchanged. Class codes are 3 = design-house secret, 2 = vendor secret, 1 = end-user secret and 0 = open.
- R3: With register tags built, a write through cfg_tag_we/cfg_tag_idx/cfg_tag_val changes one port's class until cfg_lock has been pulsed. After that, writes are ignored and the lock holds until reset.
- R4: A record leaves on the output only if dbg_level is greater than or equal to its class. Any other record never appears at the output.
- R5: Class-0 records pass while dbg_level is 0.
- R6: At most one producer handshake (src_valid and src_ready) happens per cycle. Among requesting ports, the grant rotates upward, starting from the port after the one granted last.
- R7: While out_valid is high and out_ready is low, the output record stays unchanged. Records from each port come out in the order they were accepted, and none is lost.
- R8: A record whose class exceeds dbg_level is accepted and discarded even while the output is stalled.
- R9: Each discarded record adds one to the counter of its class at drop_cnt[c*CNT_W +: CNT_W]. The counter stops at its all-ones value.
- R10: dbg_level changes only in a cycle with dbg_auth_set high, and only to a higher value. A request for a lower or equal level is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_valid | input | NUM_SRC | Per-port record valid |
| src_payload | input | NUM_SRC*PAYLOAD_W | Per-port payloads, port i at bits [i*PAYLOAD_W +: PAYLOAD_W] |
| src_ready | output | NUM_SRC | Per-port record accepted |
| cfg_tag_we | input | 1 | Class table write strobe |
| cfg_tag_idx | input | IDX_W | Port index to write |
| cfg_tag_val | input | 2 | Class value to write |
| cfg_lock | input | 1 | Sets the sticky class-table lock |
| dbg_auth_set | input | 1 | Authenticated debugger level set strobe |
| dbg_auth_level | input | 2 | Requested debugger level |
| dbg_level | output | 2 | Current debugger level |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Sink accepts the output record |
| out_tag | output | 2 | Class of the output record |
| out_src | output | IDX_W | Port index of the output record |
| out_payload | output | PAYLOAD_W | Payload of the output record |
| drop_cnt | output | 4*CNT_W | Saturating discard counters, one per class |

## Verification
The bench builds five ports, 32-bit payloads, register-based classes and a 3-bit counter width. The short counters reach saturation within a few dozen discards. The register variant lets the bench rewrite a class before the lock and try a rewrite after it. With five ports the rotation order can be seen over many full rounds. Using five ports, which is not a power of two, also exercises wraparound of the grant pointer and index values that do not map to a port.

// File: rtl/tg_pkg.sv
package tg_pkg;

   typedef enum logic [1:0] {
      PRIV_OPEN   = 2'd0,
      PRIV_USER   = 2'd1,
      PRIV_VENDOR = 2'd2,
      PRIV_HOUSE  = 2'd3
   } priv_e;

   localparam int unsigned TAG_W   = 2;
   localparam int unsigned CLASS_N = 4;

endpackage

// File: rtl/tg_tag_bank.sv
module tg_tag_bank #(
   parameter int unsigned NUM_SRC  = 5,
   parameter int unsigned IDX_W    = 3,
   parameter logic [2*NUM_SRC-1:0] TAG_INIT = '0,
   parameter bit          FROM_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [1:0]       wr_tag,
   input  logic             lock_req,
   output logic [1:0]       tags_o [NUM_SRC],
   output logic             locked_o
);

   generate
      if (FROM_REG) begin : g_reg
         logic [1:0] tag_q [NUM_SRC];
         logic       lock_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lock_q <= 1'b0;
               for (int i = 0; i < NUM_SRC; i++) tag_q[i] <= TAG_INIT[2*i +: 2];
            end else begin
               if (lock_req) lock_q <= 1'b1;
               if (wr_en && !lock_q && (int'(wr_idx) < NUM_SRC))
                  tag_q[wr_idx] <= wr_tag;
            end
         end

         always_comb begin
            for (int i = 0; i < NUM_SRC; i++) tags_o[i] = tag_q[i];
         end
         assign locked_o = lock_q;
      end else begin : g_fixed
         logic unused_cfg;
         assign unused_cfg = ^{wr_en, wr_idx, wr_tag, lock_req, clk, rst_n};
         always_comb begin
            for (int i = 0; i < NUM_SRC; i++) tags_o[i] = TAG_INIT[2*i +: 2];
         end
         assign locked_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/tg_rr_arb.sv
module tg_rr_arb #(
   parameter int unsigned N     = 5,
   parameter int unsigned IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   output logic [N-1:0]     gnt,
   output logic [IDX_W-1:0] gnt_idx,
   output logic             gnt_any
);

   logic [IDX_W-1:0] ptr_q;

   always_comb begin
      int c;
      gnt     = '0;
      gnt_idx = '0;
      gnt_any = 1'b0;
      for (int k = 1; k <= N; k++) begin
         c = (int'(ptr_q) + k) % N;
         if (!gnt_any && req[c]) begin
            gnt[c]  = 1'b1;
            gnt_idx = IDX_W'(c);
            gnt_any = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr_q <= IDX_W'(N - 1);
      else if (gnt_any) ptr_q <= gnt_idx;
   end

endmodule

// File: rtl/tg_priv_gate.sv
module tg_priv_gate
   import tg_pkg::*;
#(
   parameter int unsigned N     = 5,
   parameter int unsigned CNT_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [1:0]               tags [N],
   input  logic                     auth_set,
   input  logic [1:0]               auth_level,
   input  logic                     drop_en,
   input  logic [1:0]               drop_tag,
   output logic [N-1:0]             allow,
   output logic [1:0]               level_o,
   output logic [CLASS_N*CNT_W-1:0] drop_cnt_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   priv_e level_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         level_q <= PRIV_OPEN;
      else if (auth_set && (auth_level > level_q))
         level_q <= priv_e'(auth_level);
   end

   always_comb begin
      for (int i = 0; i < N; i++) allow[i] = (tags[i] <= level_q);
   end
   assign level_o = level_q;

   genvar c;
   generate
      for (c = 0; c < CLASS_N; c++) begin : g_cnt
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (drop_en && (drop_tag == 2'(c)) && (cnt_q != CNT_MAX))
               cnt_q <= cnt_q + 1'b1;
         end
         assign drop_cnt_o[c*CNT_W +: CNT_W] = cnt_q;
      end
   endgenerate

endmodule

// File: rtl/trace_guard_top.sv
module trace_guard_top
   import tg_pkg::*;
#(
   parameter int unsigned NUM_SRC   = 5,
   parameter int unsigned PAYLOAD_W = 32,
   parameter int unsigned CNT_W     = 16,
   parameter bit          TAGS_FROM_REG = 1'b0,
   parameter logic [2*NUM_SRC-1:0] TAG_INIT = 10'b00_11_01_10_11,
   localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_SRC-1:0]           src_valid,
   input  logic [NUM_SRC*PAYLOAD_W-1:0] src_payload,
   output logic [NUM_SRC-1:0]           src_ready,
   input  logic                         cfg_tag_we,
   input  logic [IDX_W-1:0]             cfg_tag_idx,
   input  logic [1:0]                   cfg_tag_val,
   input  logic                         cfg_lock,
   input  logic                         dbg_auth_set,
   input  logic [1:0]                   dbg_auth_level,
   output logic [1:0]                   dbg_level,
   output logic                         out_valid,
   input  logic                         out_ready,
   output logic [1:0]                   out_tag,
   output logic [IDX_W-1:0]             out_src,
   output logic [PAYLOAD_W-1:0]         out_payload,
   output logic [CLASS_N*CNT_W-1:0]     drop_cnt
);

   generate
      if (NUM_SRC < 2)    begin : g_bad_n   $error("NUM_SRC must be at least 2"); end
      if (PAYLOAD_W < 1)  begin : g_bad_pw  $error("PAYLOAD_W must be at least 1"); end
      if (CNT_W < 1)      begin : g_bad_cnt $error("CNT_W must be at least 1"); end
   endgenerate

   logic [1:0]             src_tags [NUM_SRC];
   logic [2*NUM_SRC-1:0]   tag_flat;
   logic                   tags_locked;
   logic [NUM_SRC-1:0]     allow;
   logic [NUM_SRC-1:0]     req;
   logic [NUM_SRC-1:0]     gnt;
   logic [IDX_W-1:0]       gnt_idx;
   logic                   gnt_any;
   logic                   can_accept;
   logic                   sel_allow;
   logic [1:0]             sel_tag;
   logic [PAYLOAD_W-1:0]   sel_pay;
   logic                   load;
   logic                   drop;

   logic                   ov_q;
   logic [1:0]             otag_q;
   logic [IDX_W-1:0]       osrc_q;
   logic [PAYLOAD_W-1:0]   opay_q;

   tg_tag_bank #(
      .NUM_SRC (NUM_SRC),
      .IDX_W   (IDX_W),
      .TAG_INIT(TAG_INIT),
      .FROM_REG(TAGS_FROM_REG)
   ) tag_bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_tag_we),
      .wr_idx  (cfg_tag_idx),
      .wr_tag  (cfg_tag_val),
      .lock_req(cfg_lock),
      .tags_o  (src_tags),
      .locked_o(tags_locked)
   );

   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) tag_flat[2*i +: 2] = src_tags[i];
   end

   tg_priv_gate #(
      .N    (NUM_SRC),
      .CNT_W(CNT_W)
   ) gate_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tags      (src_tags),
      .auth_set  (dbg_auth_set),
      .auth_level(dbg_auth_level),
      .drop_en   (drop),
      .drop_tag  (sel_tag),
      .allow     (allow),
      .level_o   (dbg_level),
      .drop_cnt_o(drop_cnt)
   );

   // a port competes when its record can be stored, or will be discarded anyway
   assign can_accept = !ov_q || out_ready;
   assign req        = src_valid & ({NUM_SRC{can_accept}} | ~allow);

   tg_rr_arb #(
      .N    (NUM_SRC),
      .IDX_W(IDX_W)
   ) arb_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .gnt    (gnt),
      .gnt_idx(gnt_idx),
      .gnt_any(gnt_any)
   );

   assign src_ready = gnt;

   always_comb begin
      sel_tag   = '0;
      sel_pay   = '0;
      sel_allow = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (gnt[i]) begin
            sel_tag   = src_tags[i];
            sel_pay   = src_payload[i*PAYLOAD_W +: PAYLOAD_W];
            sel_allow = allow[i];
         end
      end
   end

   assign load = gnt_any && sel_allow;
   assign drop = gnt_any && !sel_allow;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ov_q   <= 1'b0;
         otag_q <= '0;
         osrc_q <= '0;
         opay_q <= '0;
      end else if (load) begin
         ov_q   <= 1'b1;
         otag_q <= sel_tag;
         osrc_q <= gnt_idx;
         opay_q <= sel_pay;
      end else if (out_ready) begin
         ov_q   <= 1'b0;
      end
   end

   assign out_valid   = ov_q;
   assign out_tag     = otag_q;
   assign out_src     = osrc_q;
   assign out_payload = opay_q;

endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
   parameter int unsigned NUM_SRC   = 5,
   parameter int unsigned PAYLOAD_W = 32,
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned IDX_W     = 3
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic [NUM_SRC-1:0]     src_valid,
   input logic [NUM_SRC-1:0]     src_ready,
   input logic                   out_valid,
   input logic                   out_ready,
   input logic [1:0]             out_tag,
   input logic [IDX_W-1:0]       out_src,
   input logic [PAYLOAD_W-1:0]   out_payload,
   input logic [1:0]             dbg_level,
   input logic [4*CNT_W-1:0]     drop_cnt,
   input logic                   tags_locked,
   input logic [2*NUM_SRC-1:0]   tag_flat
);

   localparam logic [CNT_W-1:0] CMAX = '1;

   // R6: never more than one producer handshake per cycle
   p_single_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(src_valid & src_ready));

   // R7: a stalled output record is held
   p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_tag)
                                     && $stable(out_src) && $stable(out_payload)));

   // R4: nothing above the debugger level is presented
   p_tag_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_tag <= dbg_level));

   // R10: the debugger level never falls
   p_level_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (dbg_level >= $past(dbg_level)));

   // R3: a locked class table stays locked and unchanged
   p_tag_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tags_locked |=> (tags_locked && $stable(tag_flat)));

   genvar c;
   generate
      for (c = 0; c < 4; c++) begin : g_sat
         // R9: a full counter stays full
         p_cnt_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (drop_cnt[c*CNT_W +: CNT_W] == CMAX) |=> (drop_cnt[c*CNT_W +: CNT_W] == CMAX));
      end
   endgenerate

endmodule

bind trace_guard_top tg_checker #(
   .NUM_SRC  (NUM_SRC),
   .PAYLOAD_W(PAYLOAD_W),
   .CNT_W    (CNT_W),
   .IDX_W    (IDX_W)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_valid  (src_valid),
   .src_ready  (src_ready),
   .out_valid  (out_valid),
   .out_ready  (out_ready),
   .out_tag    (out_tag),
   .out_src    (out_src),
   .out_payload(out_payload),
   .dbg_level  (dbg_level),
   .drop_cnt   (drop_cnt),
   .tags_locked(tags_locked),
   .tag_flat   (tag_flat)
);

// File: tb/trace_guard_top_tb_top.sv
module trace_guard_top_tb_top;

   localparam int NS   = 5;
   localparam int PW   = 32;
   localparam int CW   = 3;
   localparam int IW   = 3;
   localparam int CMAX = (1 << CW) - 1;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NS-1:0]    src_valid = '0;
   logic [NS*PW-1:0] src_payload;
   logic [NS-1:0]    src_ready;
   logic             cfg_tag_we = 1'b0;
   logic [IW-1:0]    cfg_tag_idx = '0;
   logic [1:0]       cfg_tag_val = '0;
   logic             cfg_lock = 1'b0;
   logic             dbg_auth_set = 1'b0;
   logic [1:0]       dbg_auth_level = '0;
   logic [1:0]       dbg_level;
   logic             out_valid;
   logic             out_ready = 1'b0;
   logic [1:0]       out_tag;
   logic [IW-1:0]    out_src;
   logic [PW-1:0]    out_payload;
   logic [4*CW-1:0]  drop_cnt;

   always #5 clk = ~clk;

   trace_guard_top #(
      .NUM_SRC(NS), .PAYLOAD_W(PW), .CNT_W(CW), .TAGS_FROM_REG(1'b1),
      .TAG_INIT(10'b00_11_01_10_11)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_payload(src_payload),
      .src_ready(src_ready), .cfg_tag_we(cfg_tag_we), .cfg_tag_idx(cfg_tag_idx),
      .cfg_tag_val(cfg_tag_val), .cfg_lock(cfg_lock), .dbg_auth_set(dbg_auth_set),
      .dbg_auth_level(dbg_auth_level), .dbg_level(dbg_level), .out_valid(out_valid),
      .out_ready(out_ready), .out_tag(out_tag), .out_src(out_src),
      .out_payload(out_payload), .drop_cnt(drop_cnt)
   );

   int          total = 0;
   int          bad   = 0;
   bit          done  = 1'b0;
   logic [PW-1:0] sp [NS];
   int          seqn [NS];
   int          fire_cnt [NS];
   bit          fired [NS];
   logic [1:0]  mtag [NS];
   int          mlvl = 0;
   int          mdrop [4];
   logic [33:0] exp_q [NS][$];
   int          outs_per_src [NS];
   bit          prev_out_fire = 1'b0;
   int          prev_src = 0;
   bit          rr_on = 1'b0;
   bit          hold_pend = 1'b0;
   logic [35:0] hold_rec;

   always_comb begin
      for (int i = 0; i < NS; i++) src_payload[i*PW +: PW] = sp[i];
   end

   task automatic check(input bit ok, input string rq, input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
      end
   endtask

   function automatic int sat_inc(input int v);
      return (v >= CMAX) ? CMAX : v + 1;
   endfunction

   // one cycle: starts at a falling edge, samples just before the rising edge
   task automatic cycle(input logic [NS-1:0] mask, input int pv, input int pr);
      logic [35:0] cur;
      for (int i = 0; i < NS; i++) begin
         if (fired[i]) begin src_valid[i] = 1'b0; fired[i] = 1'b0; end
         if (!src_valid[i] && mask[i] && (($urandom % 100) < pv)) begin
            src_valid[i] = 1'b1;
            sp[i] = {8'(i), 24'(seqn[i])};
            seqn[i]++;
         end
      end
      out_ready = (($urandom % 100) < pr);
      #4;
      cur = {out_tag, 1'b0, out_src, out_payload};
      if (hold_pend) begin
         check(out_valid && cur == hold_rec, "R7 held record", longint'(cur), longint'(hold_rec));
      end
      hold_pend = out_valid && !out_ready;
      hold_rec  = cur;
      for (int i = 0; i < NS; i++) begin
         if (src_valid[i] && src_ready[i]) begin
            fired[i] = 1'b1;
            fire_cnt[i]++;
            if (int'(mtag[i]) <= mlvl) exp_q[i].push_back({mtag[i], sp[i]});
            else mdrop[mtag[i]] = sat_inc(mdrop[mtag[i]]);
         end
      end
      if (out_valid && out_ready) begin
         int s;
         s = int'(out_src);
         check(s < NS, "R2 source index", s, NS - 1);
         if (s < NS) begin
            outs_per_src[s]++;
            check(exp_q[s].size() > 0, "R7 unexpected record", s, -1);
            if (exp_q[s].size() > 0) begin
               logic [33:0] e;
               e = exp_q[s].pop_front();
               check(out_payload == e[31:0], "R2 payload", out_payload, e[31:0]);
               check(out_tag == e[33:32], "R2 tag", out_tag, e[33:32]);
            end
            check(int'(out_tag) <= mlvl, "R4 tag within level", out_tag, mlvl);
            if (rr_on && prev_out_fire)
               check(s == (prev_src + 1) % NS, "R6 rotation", s, (prev_src + 1) % NS);
            prev_src = s;
         end
         prev_out_fire = 1'b1;
      end else begin
         prev_out_fire = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic check_drops(input string tag);
      for (int c = 0; c < 4; c++)
         check(int'(drop_cnt[c*CW +: CW]) == mdrop[c], tag, drop_cnt[c*CW +: CW], mdrop[c]);
   endtask

   task automatic drain();
      for (int k = 0; k < 300; k++) begin
         bit empty;
         empty = !out_valid && (src_valid == '0);
         for (int i = 0; i < NS; i++) if (exp_q[i].size() != 0) empty = 1'b0;
         if (empty) break;
         cycle('0, 0, 100);
      end
   endtask

   task automatic tag_write(input int idx, input logic [1:0] v);
      cfg_tag_we = 1'b1; cfg_tag_idx = IW'(idx); cfg_tag_val = v;
      @(negedge clk);
      cfg_tag_we = 1'b0;
   endtask

   task automatic set_level(input int lv);
      dbg_auth_set = 1'b1; dbg_auth_level = 2'(lv);
      @(negedge clk);
      dbg_auth_set = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int before0, open_before;
      void'($urandom(32'd20240611));
      for (int i = 0; i < NS; i++) begin
         sp[i] = '0; seqn[i] = 0; fire_cnt[i] = 0; fired[i] = 0; outs_per_src[i] = 0;
      end
      for (int c = 0; c < 4; c++) mdrop[c] = 0;
      mtag[0] = 2'd3; mtag[1] = 2'd2; mtag[2] = 2'd1; mtag[3] = 2'd3; mtag[4] = 2'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      check(out_valid == 1'b0, "R1 out_valid", out_valid, 0);
      check(dbg_level == 2'd0, "R1 dbg_level", dbg_level, 0);
      check(drop_cnt == '0, "R1 drop counters", drop_cnt, 0);

      // R9 / R5 / R4: level 0, only open records pass
      for (int k = 0; k < 4; k++) cycle(5'b11111, 100, 100);
      check_drops("R9 counters early");
      for (int k = 0; k < 300; k++) cycle(5'b11111, 60, 70);
      drain();
      check_drops("R9 counters saturated");
      check(outs_per_src[4] > 0, "R5 open records pass at level 0", outs_per_src[4], 1);
      check(outs_per_src[0] + outs_per_src[1] + outs_per_src[2] + outs_per_src[3] == 0,
            "R4 no restricted record at level 0",
            outs_per_src[0] + outs_per_src[1] + outs_per_src[2] + outs_per_src[3], 0);

      // R3: rewrite port 2 to open, lock, try rewrite to house secret
      tag_write(2, 2'd0); mtag[2] = 2'd0;
      cfg_lock = 1'b1; @(negedge clk); cfg_lock = 1'b0;
      tag_write(2, 2'd3);
      tag_write(4, 2'd3);
      open_before = outs_per_src[2];
      for (int k = 0; k < 40; k++) cycle(5'b10100, 100, 100);
      drain();
      check(outs_per_src[2] > open_before, "R3 locked class unchanged (port 2 still open)",
            outs_per_src[2] - open_before, 1);

      // R10: raise to 2, a lower request and a request without strobe are ignored
      set_level(2); mlvl = 2;
      check(dbg_level == 2'd2, "R10 raised level", dbg_level, 2);
      set_level(1);
      check(dbg_level == 2'd2, "R10 lower request ignored", dbg_level, 2);
      dbg_auth_level = 2'd3; @(negedge clk);
      check(dbg_level == 2'd2, "R10 no strobe no change", dbg_level, 2);

      for (int k = 0; k < 400; k++) cycle(5'b11111, 60, 50);
      drain();

      // R8: stall the output with an allowed record, blocked port still drains
      for (int k = 0; k < 3; k++) cycle(5'b00010, 100, 0);
      before0 = fire_cnt[0];
      for (int k = 0; k < 4; k++) cycle(5'b00001, 100, 0);
      check(fire_cnt[0] - before0 == 4, "R8 blocked records accepted while stalled",
            fire_cnt[0] - before0, 4);
      check(out_valid && out_src == 3'd1, "R7 stalled record still presented", out_src, 1);
      drain();

      // R6: all ports always valid at level 3
      set_level(3); mlvl = 3;
      rr_on = 1'b1;
      for (int k = 0; k < 40; k++) cycle(5'b11111, 100, 100);
      rr_on = 1'b0;
      for (int k = 0; k < 300; k++) cycle(5'b11111, 50, 60);
      drain();
      for (int i = 0; i < NS; i++)
         check(exp_q[i].size() == 0, "R7 no record lost", exp_q[i].size(), 0);
      check_drops("R9 counters final");

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule